// File: doc/BRIEF.md
# Multi-Sensor Scan Host Controller

This block is the host-side sequencer for a group of up to eight light sensors. The sensors share one serial enable, one serial clock and one data line, plus a common output-enable line. Each sensor is told apart by a 3-bit address. A single start pulse runs a full scan. In the first pass, every sensor in the group receives a 16-bit configuration write that carries its 8-bit trim code; output-enable is low for this pass. In the second pass, output-enable is raised and each sensor is picked in turn with a short 8-bit selection frame.

After each selection, the controller waits for the sensor's detection time. That time comes from the conversion-time field of the trim code just written, and is twice the slowest conversion time for that setting. The wait also covers the output settling time. When it ends, the controller pulses a capture strobe for an external converter and shows the sensor's address next to it. A one-cycle done pulse closes the scan.

All bus timing is counted in system clocks. The count is derived from a clocks-per-microsecond parameter and a run-time half-period divider. The divider is clamped so the serial clock never runs faster than the sensors allow.

Top module: `scan_host_ctrl`

## Requirements
- R1: After reset and whenever no scan is running, all outputs are low.
- R2: Configuration pass, with output-enable low. For sensor addresses 0 up to N-1, one 16-bit frame is sent per sensor, MSB first. The frame layout is: bit 15 = 0 (write), bits 14:12 = address, bits 11:8 = 0, bits 7:0 = that sensor's trim code. The trim code is taken from trim_table[8*a+7 : 8*a].
- R3: Serial timing. The serial clock idles low while enable is high. Every clock phase lasts H = max(clk_div, ceil(50 ns)) system cycles. Data is shown at enable rise and after each falling clock edge, and never changes while the clock is high. Enable rises H cycles before the first rising clock edge. Enable falls max(H, ceil(140 ns)) cycles after the last falling clock edge.
- R4: Enable stays low for ceil(100 ns) cycles (at least one) before every frame. Output-enable changes only while enable is low, and never in the cycle right before enable rises.
- R5: Selection pass, with output-enable high. One 8-bit frame is sent per sensor, in ascending address order. The frame layout is: bit 7 = 0, bits 6:4 = address, bits 3:0 = 0.
- R6: After each selection frame ends, the bus stays idle for (60 << ts) µs worth of system cycles. Here ts is bits 5:4 of that sensor's trim code. The 2 µs settling time is covered because it is never the larger of the two.
- R7: Right after each wait, cap_stb is high for exactly one cycle and cap_addr shows the address just selected. At all other times cap_addr is 0.
- R8: One cycle after the last capture strobe, scan_done pulses for one cycle and output-enable returns low in that same cycle.
- R9: A start pulse that arrives while a scan is running is ignored. It does not restart the scan and it does not cause a second scan.
- R10: A sensor count of 0 makes scan_done pulse in the cycle after start, with no frames sent. A count above the maximum is treated as the maximum.
- R11: The count, the divider and the trim table are captured when the scan starts. Changing them during a scan has no effect on that scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a scan (accepted only when idle) |
| sensor_count | input | $clog2(MAX_SENSORS+1) | Number of sensors to scan |
| clk_div | input | DIV_W | Serial clock half-period in system cycles (clamped to the minimum) |
| trim_table | input | 8*MAX_SENSORS | Trim code per sensor; sensor a uses bits 8a+7 down to 8a |
| bus_sen | output | 1 | Serial frame enable |
| bus_sclk | output | 1 | Serial clock |
| bus_sdata | output | 1 | Serial data |
| bus_oe | output | 1 | Shared output-enable line |
| cap_stb | output | 1 | One-cycle converter capture strobe |
| cap_addr | output | 3 | Address of the sensor being captured |
| scan_done | output | 1 | One-cycle end-of-scan pulse |

## Verification
Most wrong internal states surface on the bus pins within a few system cycles. A bit counter that is off gives one clock pulse too many or too few before enable drops. A wrong sensor index appears in the address bits of the next frame and in cap_addr. A wrong wait length moves the capture strobe early or late by whole cycles. The bench predicts every output pin for every cycle from the requirements alone. A fault is therefore reported in the first cycle it reaches any pin, not only at the end of a scan. Separate runs cover a stray start pulse and input changes made mid-scan. In those runs the expected waveform stays fixed by what was captured at start.

// File: rtl/scan_host_pkg.sv
package scan_host_pkg;

    localparam int ADDR_BITS  = 3;
    localparam int TRIM_BITS  = 8;
    localparam int FRAME_BITS = 16;
    localparam int SETTLE_US  = 2;

    typedef logic [ADDR_BITS-1:0]  addr_t;
    typedef logic [TRIM_BITS-1:0]  trim_t;
    typedef logic [FRAME_BITS-1:0] frame_t;

    typedef enum logic [2:0] {
        SQ_IDLE, SQ_CFG, SQ_SEL, SQ_WAIT, SQ_CAP, SQ_DONE
    } seq_state_t;

    typedef enum logic [2:0] {
        TX_IDLE, TX_GAP, TX_LEAD, TX_HI, TX_LO, TX_TAIL
    } tx_phase_t;

    // Configuration word: write flag, address, four zeros, trim code.
    function automatic frame_t cfg_word(addr_t a, trim_t t);
        return {1'b0, a, 4'b0000, t};
    endfunction

    // Selection word, left-aligned so bit 15 goes out first.
    function automatic frame_t sel_word(addr_t a);
        return {1'b0, a, 4'b0000, 8'h00};
    endfunction

    // Round a duration in ns up to whole system cycles, minimum one.
    function automatic int unsigned ns_to_cycles(int unsigned ns, int unsigned cyc_per_us);
        int unsigned v;
        v = (ns * cyc_per_us + 999) / 1000;
        return (v == 0) ? 1 : v;
    endfunction

    // Detection time in microseconds for a conversion-time code.
    function automatic int unsigned detect_us(logic [1:0] ts);
        return 32'd60 << ts;
    endfunction

endpackage

// File: rtl/sh_frame_tx.sv
module sh_frame_tx
    import scan_host_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         go,
    input  frame_t       word,
    input  logic [4:0]   nbits,
    input  logic [W-1:0] half,
    input  logic [W-1:0] tail,
    input  logic [W-1:0] guard,
    output logic         sen,
    output logic         sclk,
    output logic         sdata,
    output logic         last
);

    tx_phase_t    ph;
    logic [W-1:0] cnt;
    frame_t       shreg;
    logic [4:0]   left;
    logic         step_done;

    assign step_done = (cnt == '0);
    assign last      = (ph == TX_TAIL) && step_done;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph    <= TX_IDLE;
            cnt   <= '0;
            shreg <= '0;
            left  <= '0;
            sen   <= 1'b0;
            sclk  <= 1'b0;
            sdata <= 1'b0;
        end else if (go && (ph == TX_IDLE || last)) begin
            ph    <= TX_GAP;
            cnt   <= guard - W'(1);
            shreg <= word;
            left  <= nbits;
            sen   <= 1'b0;
            sclk  <= 1'b0;
            sdata <= 1'b0;
        end else if (ph != TX_IDLE) begin
            if (!step_done) begin
                cnt <= cnt - W'(1);
            end else begin
                case (ph)
                    TX_GAP: begin
                        ph    <= TX_LEAD;
                        cnt   <= half - W'(1);
                        sen   <= 1'b1;
                        sdata <= shreg[FRAME_BITS-1];
                    end
                    TX_LEAD: begin
                        ph   <= TX_HI;
                        cnt  <= half - W'(1);
                        sclk <= 1'b1;
                    end
                    TX_HI: begin
                        sclk <= 1'b0;
                        if (left == 5'd1) begin
                            ph  <= TX_TAIL;
                            cnt <= tail - W'(1);
                        end else begin
                            ph    <= TX_LO;
                            cnt   <= half - W'(1);
                            shreg <= {shreg[FRAME_BITS-2:0], 1'b0};
                            sdata <= shreg[FRAME_BITS-2];
                            left  <= left - 5'd1;
                        end
                    end
                    TX_LO: begin
                        ph   <= TX_HI;
                        cnt  <= half - W'(1);
                        sclk <= 1'b1;
                    end
                    TX_TAIL: begin
                        ph    <= TX_IDLE;
                        sen   <= 1'b0;
                        sdata <= 1'b0;
                    end
                    default: ph <= TX_IDLE;
                endcase
            end
        end
    end

    // R3: the serial clock only toggles inside an enabled frame
    p_sclk_inside_frame_r3: assert property (@(posedge clk) disable iff (rst)
        sclk |-> sen);

    // R3: data moves only together with a falling clock edge
    p_data_on_fall_r3: assert property (@(posedge clk) disable iff (rst)
        (sen && $past(sen) && (sdata != $past(sdata))) |-> (!sclk && $past(sclk)));

    // R3: a frame opens with the clock low
    p_lead_low_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(sen) |-> !sclk);

endmodule

// File: rtl/sh_wait_timer.sv
module sh_wait_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] val,
    output logic          zero
);

    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= val - TW'(1);
        end else if (cnt != '0) begin
            cnt <= cnt - TW'(1);
        end
    end

    assign zero = (cnt == '0);

    // R6: a load never asks for an empty wait
    p_load_nonzero_r6: assert property (@(posedge clk) disable iff (rst)
        load |-> (val != '0));

endmodule

// File: rtl/sh_scan_seq.sv
module sh_scan_seq
    import scan_host_pkg::*;
#(
    parameter int CYC_PER_US  = 100,
    parameter int MAX_SENSORS = 8,
    parameter int DIV_W       = 8,
    parameter int CNT_W       = 4,
    parameter int TW          = 16,
    parameter int MIN_HALF    = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] count_in,
    input  logic [DIV_W-1:0] div_in,
    input  trim_t            trim_in [MAX_SENSORS],
    input  logic             tx_last,
    input  logic             tmr_zero,
    output logic             tx_go,
    output frame_t           tx_word,
    output logic [4:0]       tx_nbits,
    output logic [DIV_W-1:0] half_q,
    output logic             tmr_load,
    output logic [TW-1:0]    tmr_val,
    output logic             oe,
    output logic             cap_stb,
    output addr_t            cap_addr,
    output logic             done
);

    localparam logic [CNT_W-1:0] MAX_C   = CNT_W'(MAX_SENSORS);
    localparam logic [DIV_W-1:0] HALF_LO = DIV_W'(MIN_HALF);

    seq_state_t       state;
    addr_t            idx;
    addr_t            last_idx;
    addr_t            nxt_idx;
    trim_t            trim_q [MAX_SENSORS];
    logic [CNT_W-1:0] cnt_eff;

    function automatic logic [TW-1:0] wait_len(logic [1:0] ts);
        int unsigned us;
        us = detect_us(ts);
        if (us < SETTLE_US) us = SETTLE_US;
        return TW'(us * CYC_PER_US);
    endfunction

    assign cnt_eff = (count_in > MAX_C) ? MAX_C : count_in;
    assign nxt_idx = idx + addr_t'(1);

    always_comb begin
        tx_go    = 1'b0;
        tx_word  = '0;
        tx_nbits = '0;
        case (state)
            SQ_IDLE: if (start && cnt_eff != '0) begin
                tx_go    = 1'b1;
                tx_word  = cfg_word('0, trim_in[0]);
                tx_nbits = 5'd16;
            end
            SQ_CFG: if (tx_last) begin
                tx_go = 1'b1;
                if (idx == last_idx) begin
                    tx_word  = sel_word('0);
                    tx_nbits = 5'd8;
                end else begin
                    tx_word  = cfg_word(nxt_idx, trim_q[nxt_idx]);
                    tx_nbits = 5'd16;
                end
            end
            SQ_CAP: if (idx != last_idx) begin
                tx_go    = 1'b1;
                tx_word  = sel_word(nxt_idx);
                tx_nbits = 5'd8;
            end
            default: ;
        endcase
    end

    assign tmr_load = (state == SQ_SEL) && tx_last;
    assign tmr_val  = wait_len(trim_q[idx][5:4]);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SQ_IDLE;
            idx      <= '0;
            last_idx <= '0;
            half_q   <= HALF_LO;
            oe       <= 1'b0;
            cap_stb  <= 1'b0;
            cap_addr <= '0;
            done     <= 1'b0;
            for (int i = 0; i < MAX_SENSORS; i++) trim_q[i] <= '0;
        end else begin
            cap_stb <= 1'b0;
            done    <= 1'b0;
            case (state)
                SQ_IDLE: if (start) begin
                    half_q   <= (div_in < HALF_LO) ? HALF_LO : div_in;
                    trim_q   <= trim_in;
                    last_idx <= addr_t'(cnt_eff - CNT_W'(1));
                    idx      <= '0;
                    if (cnt_eff == '0) begin
                        state <= SQ_DONE;
                        done  <= 1'b1;
                    end else begin
                        state <= SQ_CFG;
                    end
                end
                SQ_CFG: if (tx_last) begin
                    if (idx == last_idx) begin
                        state <= SQ_SEL;
                        idx   <= '0;
                        oe    <= 1'b1;
                    end else begin
                        idx <= nxt_idx;
                    end
                end
                SQ_SEL: if (tx_last) state <= SQ_WAIT;
                SQ_WAIT: if (tmr_zero) begin
                    state    <= SQ_CAP;
                    cap_stb  <= 1'b1;
                    cap_addr <= idx;
                end
                SQ_CAP: begin
                    cap_addr <= '0;
                    if (idx == last_idx) begin
                        state <= SQ_DONE;
                        done  <= 1'b1;
                        oe    <= 1'b0;
                    end else begin
                        idx   <= nxt_idx;
                        state <= SQ_SEL;
                    end
                end
                SQ_DONE: state <= SQ_IDLE;
                default: state <= SQ_IDLE;
            endcase
        end
    end

    // R7: capture strobe never lasts longer than one cycle
    p_strobe_single_r7: assert property (@(posedge clk) disable iff (rst)
        cap_stb |=> !cap_stb);

    // R8: done is a single-cycle pulse
    p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8: output-enable is low when the scan reports completion
    p_done_oe_low_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> !oe);

endmodule

// File: rtl/scan_host_ctrl.sv
module scan_host_ctrl
    import scan_host_pkg::*;
#(
    parameter int CYC_PER_US  = 100,
    parameter int MAX_SENSORS = 8,
    parameter int DIV_W       = 8
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             start,
    input  logic [$clog2(MAX_SENSORS+1)-1:0] sensor_count,
    input  logic [DIV_W-1:0]                 clk_div,
    input  logic [MAX_SENSORS*TRIM_BITS-1:0] trim_table,
    output logic                             bus_sen,
    output logic                             bus_sclk,
    output logic                             bus_sdata,
    output logic                             bus_oe,
    output logic                             cap_stb,
    output logic [ADDR_BITS-1:0]             cap_addr,
    output logic                             scan_done
);

    localparam int CNT_W    = $clog2(MAX_SENSORS + 1);
    localparam int TW       = $clog2(480 * CYC_PER_US + 1);
    localparam int MIN_HALF = ns_to_cycles(50, CYC_PER_US);
    localparam int GUARD    = ns_to_cycles(100, CYC_PER_US);
    localparam int HOLD     = ns_to_cycles(140, CYC_PER_US);
    localparam logic [DIV_W-1:0] GUARD_V = DIV_W'(GUARD);
    localparam logic [DIV_W-1:0] HOLD_V  = DIV_W'(HOLD);

    trim_t            trim_arr [MAX_SENSORS];
    logic             tx_go, tx_last, tmr_load, tmr_zero;
    frame_t           tx_word;
    logic [4:0]       tx_nbits;
    logic [DIV_W-1:0] half_q, tail_len;
    logic [TW-1:0]    tmr_val;

    for (genvar g = 0; g < MAX_SENSORS; g++) begin : g_unpack
        assign trim_arr[g] = trim_table[g*TRIM_BITS +: TRIM_BITS];
    end

    assign tail_len = (half_q < HOLD_V) ? HOLD_V : half_q;

    sh_scan_seq #(
        .CYC_PER_US (CYC_PER_US),
        .MAX_SENSORS(MAX_SENSORS),
        .DIV_W      (DIV_W),
        .CNT_W      (CNT_W),
        .TW         (TW),
        .MIN_HALF   (MIN_HALF)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .count_in(sensor_count),
        .div_in  (clk_div),
        .trim_in (trim_arr),
        .tx_last (tx_last),
        .tmr_zero(tmr_zero),
        .tx_go   (tx_go),
        .tx_word (tx_word),
        .tx_nbits(tx_nbits),
        .half_q  (half_q),
        .tmr_load(tmr_load),
        .tmr_val (tmr_val),
        .oe      (bus_oe),
        .cap_stb (cap_stb),
        .cap_addr(cap_addr),
        .done    (scan_done)
    );

    sh_frame_tx #(.W(DIV_W)) u_tx (
        .clk  (clk),
        .rst  (rst),
        .go   (tx_go),
        .word (tx_word),
        .nbits(tx_nbits),
        .half (half_q),
        .tail (tail_len),
        .guard(GUARD_V),
        .sen  (bus_sen),
        .sclk (bus_sclk),
        .sdata(bus_sdata),
        .last (tx_last)
    );

    sh_wait_timer #(.TW(TW)) u_tmr (
        .clk (clk),
        .rst (rst),
        .load(tmr_load),
        .val (tmr_val),
        .zero(tmr_zero)
    );

    // R4: output-enable is steady for the whole of a frame
    p_oe_steady_in_frame_r4: assert property (@(posedge clk) disable iff (rst)
        (bus_sen && $past(bus_sen)) |-> (bus_oe == $past(bus_oe)));

    // R4: output-enable did not move in the cycle before a frame opens
    p_oe_gap_before_frame_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_sen) |-> (bus_oe == $past(bus_oe)));

    // R7: capture happens with the bus quiet and the outputs enabled
    p_capture_quiet_bus_r7: assert property (@(posedge clk) disable iff (rst)
        cap_stb |-> (!bus_sen && bus_oe));

endmodule

// File: tb/scan_host_ctrl_test.sv
module scan_host_ctrl_test;

    localparam int CYC  = 10;
    localparam int MAXS = 8;
    localparam int GRD  = ((100 * CYC + 999) / 1000 < 1) ? 1 : (100 * CYC + 999) / 1000;
    localparam int MINH = ((50 * CYC + 999) / 1000 < 1) ? 1 : (50 * CYC + 999) / 1000;
    localparam int HLD  = ((140 * CYC + 999) / 1000 < 1) ? 1 : (140 * CYC + 999) / 1000;

    typedef struct {
        bit       sen, sclk, sd, oe, stb, dn;
        bit [2:0] ad;
        string    tag;
        string    note;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [3:0]  count = '0;
    logic [7:0]  div = '0;
    logic [63:0] tbl = '0;
    logic        bus_sen, bus_sclk, bus_sdata, bus_oe, cap_stb, scan_done;
    logic [2:0]  cap_addr;

    exp_t  q[$];
    exp_t  cur;
    string idle_tag = "R1";
    int    nchk = 0;
    int    nfail = 0;
    int    cyc = 0;

    always #5 clk = ~clk;

    scan_host_ctrl #(.CYC_PER_US(CYC), .MAX_SENSORS(MAXS), .DIV_W(8)) uut (
        .clk(clk), .rst(rst), .start(start), .sensor_count(count), .clk_div(div),
        .trim_table(tbl), .bus_sen(bus_sen), .bus_sclk(bus_sclk), .bus_sdata(bus_sdata),
        .bus_oe(bus_oe), .cap_stb(cap_stb), .cap_addr(cap_addr), .scan_done(scan_done)
    );

    task automatic push(input int n, input bit sen, input bit sclk, input bit sd, input bit oe,
                        input bit stb, input bit [2:0] ad, input bit dn,
                        input string tag, input string note);
        exp_t e;
        e.sen = sen; e.sclk = sclk; e.sd = sd; e.oe = oe; e.stb = stb;
        e.ad = ad; e.dn = dn; e.tag = tag; e.note = note;
        for (int i = 0; i < n; i++) q.push_back(e);
    endtask

    task automatic frame(input bit [15:0] w, input int nb, input bit oe, input int h,
                         input int t, input string tag, input string note);
        push(GRD, 0, 0, 0, oe, 0, 0, 0, "R4", note);
        push(h, 1, 0, w[15], oe, 0, 0, 0, "R3", note);
        for (int k = 0; k < nb; k++) begin
            push(h, 1, 1, w[15-k], oe, 0, 0, 0, tag, note);
            if (k < nb - 1) push(h, 1, 0, w[14-k], oe, 0, 0, 0, tag, note);
        end
        push(t, 1, 0, w[16-nb], oe, 0, 0, 0, "R3", note);
    endtask

    task automatic expect_scan(input int c, input int d, input bit [63:0] tb, input string note);
        int n, h, t;
        n = (c > MAXS) ? MAXS : c;
        h = (d < MINH) ? MINH : d;
        t = (h < HLD) ? HLD : h;
        if (n == 0) begin
            push(1, 0, 0, 0, 0, 0, 0, 1, "R10", note);
            return;
        end
        for (int a = 0; a < n; a++)
            frame({1'b0, 3'(a), 4'b0000, tb[a*8 +: 8]}, 16, 1'b0, h, t, "R2", note);
        for (int a = 0; a < n; a++) begin
            frame({1'b0, 3'(a), 4'b0000, 8'h00}, 8, 1'b1, h, t, "R5", note);
            push((60 << tb[a*8+4 +: 2]) * CYC, 0, 0, 0, 1, 0, 0, 0, "R6", note);
            push(1, 0, 0, 0, 1, 1, 3'(a), 0, "R7", note);
        end
        push(1, 0, 0, 0, 0, 0, 0, 1, "R8", note);
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    endtask

    always @(negedge clk) begin
        cyc++;
        if (q.size() > 0) begin
            cur = q.pop_front();
        end else begin
            cur.sen = 0; cur.sclk = 0; cur.sd = 0; cur.oe = 0; cur.stb = 0;
            cur.ad = 0; cur.dn = 0; cur.tag = idle_tag; cur.note = "idle";
        end
        nchk++;
        if ({bus_sen, bus_sclk, bus_sdata, bus_oe, cap_stb, cap_addr, scan_done} !==
            {cur.sen, cur.sclk, cur.sd, cur.oe, cur.stb, cur.ad, cur.dn}) begin
            nfail++;
            $display("FAIL %s %s cycle %0d: sen,sclk,sdata,oe,stb,addr,done got %b%b%b%b%b %0d %b exp %b%b%b%b%b %0d %b",
                     cur.tag, cur.note, cyc, bus_sen, bus_sclk, bus_sdata, bus_oe, cap_stb,
                     cap_addr, scan_done, cur.sen, cur.sclk, cur.sd, cur.oe, cur.stb, cur.ad, cur.dn);
        end
        if (cyc > 150000) begin
            nfail++;
            $display("FAIL watchdog: run did not finish, cycle %0d, expected completion", cyc);
            summary();
        end
    end

    task automatic run_scan(input int c, input int d, input bit [63:0] tb, input string note);
        @(negedge clk);
        count = 4'(c); div = 8'(d); tbl = tb; start = 1'b1;
        @(posedge clk);
        #1 expect_scan(c, d, tb, note);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_idle();
        while (q.size() != 0) @(negedge clk);
        repeat (6) @(negedge clk);
    endtask

    initial begin
        // R1: reset state and idle after reset
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (6) @(negedge clk);

        // Three sensors, divider 0 clamps to the minimum; ts codes 0, 1, 2 (R2 R3 R6)
        run_scan(3, 0, 64'h0000_0000_002A_D50F, "three-sensor");
        wait_idle();

        // Eight sensors, divider 3, last sensor with ts 3; stray start and input
        // changes mid-scan must not alter this scan (R9, R11)
        run_scan(8, 3, 64'hF309_4E83_0AC7_418C, "R11 latched inputs");
        repeat (300) @(negedge clk);
        start = 1'b1; count = 4'd2; div = 8'd7; tbl = 64'hFFFF_FFFF_FFFF_FFFF;
        @(negedge clk);
        start = 1'b0;
        idle_tag = "R9";
        wait_idle();

        // R10: zero sensors gives an immediate done
        run_scan(0, 2, 64'h0, "zero count");
        wait_idle();

        // R10: count above the maximum clamps to eight
        run_scan(12, 2, 64'h0102_0408_1040_8001, "clamped count");
        wait_idle();

        // Single sensor, longest wait (R6, R7, R8)
        run_scan(1, 1, 64'h0000_0000_0000_003F, "single sensor");
        wait_idle();

        summary();
    end

endmodule